// File: doc/BRIEF.md
# Latched Fault Status Aggregator

This block gathers the fault indications of a battery-monitor controller into one 14-bit status word and drives a single active-low fault line. Eight single-source events feed eight of the status bits: a fault on either of two clock sources, a watchdog expiry, an open supply pin, an open ground pin, a failed register checksum comparison, a reference out of range, a regulator out of range, and a failed supply loopback at the end of a temperature scan. Four more bits summarise detailed fault vectors for over-temperature, overvoltage, undervoltage and open-wire. Each summary bit is set while any flag in its vector is set.

Every status bit is sticky. A host clears the word by writing all zeros. A summary bit cannot clear while its detailed vector still holds a set flag, and an event that is present in the cycle of a clearing write keeps its bit set. The fault line is low while any status bit is 1. The status word is read combinationally from the read port.

Top module: `fault_status_agg`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 14'h0000 and fault_n is 1.
- R2: The bit positions of the status word are: 13 loopback, 12 regulator, 11 reference, 10 checksum, 9 ground-open, 8 supply-open, 7 open-wire summary, 6 undervoltage summary, 5 overvoltage summary, 4 over-temperature summary, 3 watchdog, 2 clock-source. Bits 1:0 are reserved and always read 0.
- R3: A single-source event that is high at a clock edge sets its status bit from that edge on. The bit stays set after the event drops. The clock-source bit sets on either of its two inputs.
- R4: The over-temperature, overvoltage, undervoltage and open-wire bits set at an edge where any flag of their detailed vector (5, 12, 12 and 13 flags) is 1.
- R5: A write of 14'h0000 clears at that edge each single-source bit whose event is low.
- R6: A write of 14'h0000 clears a summary bit only if every flag of its detailed vector is 0. Otherwise the bit stays 1.
- R7: A write of any nonzero value, including one that sets only bits 1:0, leaves the status word unchanged.
- R8: An event or detailed flag that is high in the same cycle as a clearing write takes priority, and its bit is 1 after that edge.
- R9: fault_n is 0 whenever any status bit is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 14 | Host write value; only 14'h0000 clears |
| rd_data | output | 14 | Current status word |
| fault_n | output | 1 | Active-low OR of all status bits |
| clk_a_fail | input | 1 | Fault from the first clock source |
| clk_b_fail | input | 1 | Fault from the second clock source |
| wdog_expired | input | 1 | Watchdog timeout event |
| supply_open | input | 1 | Open connection on the supply pin |
| ground_open | input | 1 | Open connection on the ground pin |
| csum_mismatch | input | 1 | Register checksum comparison failed |
| vref_bad | input | 1 | Reference out of its good range |
| vreg_bad | input | 1 | A regulator out of its good range |
| loopback_fail | input | 1 | Supply loopback failed after a temperature scan |
| temp_flags | input | 5 | Detailed over-temperature flags |
| ov_flags | input | 12 | Detailed overvoltage flags |
| uv_flags | input | 12 | Detailed undervoltage flags |
| ow_flags | input | 13 | Detailed open-wire flags |

## Verification
Two functions can act in the same cycle: a host clearing write and a new fault, either a single-source event or a detailed flag that is still set. The bench provokes this in two ways. It holds a supply-open event high during a zero write, and it keeps an over-temperature flag set through a zero write that clears the other bits. It checks that only the bit whose source is still active survives. fault_n is checked against the expected word on the same cycles.

// File: rtl/fsa_pkg.sv
// Package: shared widths and bit positions of the fault status word.
// Assumes the status word layout is fixed; positions are decoded by software.
package fsa_pkg;
    localparam int STAT_W    = 14;
    localparam int RSVD_W    = 2;
    localparam int LIVE_W    = STAT_W - RSVD_W;
    localparam int TEMP_N    = 5;
    localparam int CELL_N    = 12;
    localparam int WIRE_N    = CELL_N + 1;

    localparam int B_CLK     = 2;
    localparam int B_WDOG    = 3;
    localparam int B_OT      = 4;
    localparam int B_OV      = 5;
    localparam int B_UV      = 6;
    localparam int B_OW      = 7;
    localparam int B_SUPPLY  = 8;
    localparam int B_GROUND  = 9;
    localparam int B_CSUM    = 10;
    localparam int B_VREF    = 11;
    localparam int B_VREG    = 12;
    localparam int B_LOOP    = 13;
endpackage

// File: rtl/fsa_any_reduce.sv
// Module: OR-reduces one detailed fault vector into its summary request.
// Assumes the flags are already synchronous to clk.
module fsa_any_reduce #(
    parameter int W = 12
) (
    input  logic [W-1:0] flags,
    output logic         any_set
);
    // Purpose: a summary is requested while any detailed flag is set.
    always_comb begin
        any_set = |flags;
    end
endmodule

// File: rtl/fsa_sticky_bank.sv
// Module: a bank of sticky status bits. A set request wins over a clear.
// A clear takes effect only on bits whose request is low.
// Assumes clr is a single-cycle qualified clearing strobe.
module fsa_sticky_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic         clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: latch a set request; drop the bit only on a clear with no request.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set_req[i])
                q[i] <= 1'b1;
            else if (clr)
                q[i] <= 1'b0;
        end

        // R3/R4: a request makes the bit 1 after the edge
        p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[i] |=> q[i]);
        // R3: a set bit stays set without a clear
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr) |=> q[i]);
        // R5: a clear with no request empties the bit
        p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set_req[i]) |=> !q[i]);
        // R8: a request in the clearing cycle wins
        p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && set_req[i]) |=> q[i]);
        // R7: a clear bit never rises without a request
        p_noset_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!q[i] && !set_req[i]) |=> !q[i]);
    end
endmodule

// File: rtl/fault_status_agg.sv
// Module: top of the latched fault status aggregator.
// It maps events and detailed fault summaries onto a 14-bit sticky word.
// It decodes the host clearing write and drives the active-low fault line.
// Assumes all inputs are synchronous to clk; bits 1:0 are reserved.
module fault_status_agg
    import fsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] rd_data,
    output logic              fault_n,
    input  logic              clk_a_fail,
    input  logic              clk_b_fail,
    input  logic              wdog_expired,
    input  logic              supply_open,
    input  logic              ground_open,
    input  logic              csum_mismatch,
    input  logic              vref_bad,
    input  logic              vreg_bad,
    input  logic              loopback_fail,
    input  logic [TEMP_N-1:0] temp_flags,
    input  logic [CELL_N-1:0] ov_flags,
    input  logic [CELL_N-1:0] uv_flags,
    input  logic [WIRE_N-1:0] ow_flags
);
    logic              ot_any, ov_any, uv_any, ow_any;
    logic [STAT_W-1:0] req;
    logic [LIVE_W-1:0] live_q;
    logic              clr_wr;

    fsa_any_reduce #(.W(TEMP_N)) u_red_ot (.flags(temp_flags), .any_set(ot_any));
    fsa_any_reduce #(.W(CELL_N)) u_red_ov (.flags(ov_flags),   .any_set(ov_any));
    fsa_any_reduce #(.W(CELL_N)) u_red_uv (.flags(uv_flags),   .any_set(uv_any));
    fsa_any_reduce #(.W(WIRE_N)) u_red_ow (.flags(ow_flags),   .any_set(ow_any));

    // Purpose: place every set request at its status bit position.
    always_comb begin
        req           = '0;
        req[B_CLK]    = clk_a_fail | clk_b_fail;
        req[B_WDOG]   = wdog_expired;
        req[B_OT]     = ot_any;
        req[B_OV]     = ov_any;
        req[B_UV]     = uv_any;
        req[B_OW]     = ow_any;
        req[B_SUPPLY] = supply_open;
        req[B_GROUND] = ground_open;
        req[B_CSUM]   = csum_mismatch;
        req[B_VREF]   = vref_bad;
        req[B_VREG]   = vreg_bad;
        req[B_LOOP]   = loopback_fail;
    end

    // Purpose: only a write of all zeros is a clearing write.
    always_comb begin
        clr_wr = wr_en && (wr_data == '0);
    end

    fsa_sticky_bank #(.N(LIVE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (req[STAT_W-1:RSVD_W]),
        .clr     (clr_wr),
        .q       (live_q)
    );

    // Purpose: assemble the read word with reserved bits at 0 and drive the fault line.
    always_comb begin
        rd_data = {live_q, {RSVD_W{1'b0}}};
        fault_n = ~|live_q;
    end

    // R9: any fault source drives the line low after the edge
    p_line_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> !fault_n);
    // R6: a clearing write cannot empty OV while a cell flag is set
    p_ov_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0 && |ov_flags) |=> rd_data[B_OV]);
    // R6: same guard for the open-wire summary
    p_ow_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0 && |ow_flags) |=> rd_data[B_OW]);
    // R7: a nonzero write with no events leaves the word unchanged
    p_nz_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != '0 && req == '0) |=> $stable(rd_data));
endmodule

// File: tb/fault_status_agg_tb.sv
module fault_status_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [13:0] wr_data = '0;
    logic [13:0] rd_data;
    logic        fault_n;
    logic        clk_a_fail = 0, clk_b_fail = 0, wdog_expired = 0;
    logic        supply_open = 0, ground_open = 0, csum_mismatch = 0;
    logic        vref_bad = 0, vreg_bad = 0, loopback_fail = 0;
    logic [4:0]  temp_flags = '0;
    logic [11:0] ov_flags = '0, uv_flags = '0;
    logic [12:0] ow_flags = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fault_status_agg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fault_n(fault_n),
        .clk_a_fail(clk_a_fail), .clk_b_fail(clk_b_fail),
        .wdog_expired(wdog_expired), .supply_open(supply_open),
        .ground_open(ground_open), .csum_mismatch(csum_mismatch),
        .vref_bad(vref_bad), .vreg_bad(vreg_bad),
        .loopback_fail(loopback_fail), .temp_flags(temp_flags),
        .ov_flags(ov_flags), .uv_flags(uv_flags), .ow_flags(ow_flags)
    );

    // Event word ev[11:0] maps to status bits 13..2 (ev[k] -> status bit k+2)
    localparam int NV = 12;
    localparam logic [11:0] V_EV [NV] = '{12'h000, 12'h002, 12'h000, 12'h004,
        12'h004, 12'h000, 12'h900, 12'h000, 12'h040, 12'h000, 12'hFFF, 12'h000};
    localparam logic        V_WE [NV] = '{0, 0, 0, 0, 1, 1, 0, 1, 1, 1, 0, 1};
    localparam logic [13:0] V_WD [NV] = '{14'h0, 14'h0, 14'h0, 14'h0, 14'h0,
        14'h0, 14'h0, 14'h3FFF, 14'h0, 14'h0, 14'h0, 14'h0};
    localparam logic [13:0] V_EXP [NV] = '{14'h0000, 14'h0008, 14'h0008,
        14'h0018, 14'h0010, 14'h0000, 14'h2400, 14'h2400, 14'h0100,
        14'h0000, 14'h3FFC, 14'h0000};
    localparam string V_REQ [NV] = '{"R1", "R3", "R3", "R4", "R6", "R6",
        "R2", "R7", "R8", "R5", "R2", "R5"};

    task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive_ev(input logic [11:0] ev);
        clk_a_fail    = ev[0];
        wdog_expired  = ev[1];
        temp_flags    = {1'b0, ev[2], 3'b0};
        ov_flags      = {ev[3], 11'b0};
        uv_flags      = {11'b0, ev[4]};
        ow_flags      = {ev[5], 12'b0};
        supply_open   = ev[6];
        ground_open   = ev[7];
        csum_mismatch = ev[8];
        vref_bad      = ev[9];
        vreg_bad      = ev[10];
        loopback_fail = ev[11];
    endtask

    // drive at negedge, let one posedge pass, sample 1 ns after it
    task automatic step(input logic [11:0] ev, input logic we, input logic [13:0] wd);
        @(negedge clk);
        drive_ev(ev);
        wr_en = we;
        wr_data = wd;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset word", rd_data, 14'h0000);
        chk("R1 reset line", {13'b0, fault_n}, 14'h0001);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(V_EV[i], V_WE[i], V_WD[i]);
            chk(V_REQ[i], rd_data, V_EXP[i]);
            chk("R9 line", {13'b0, fault_n}, {13'b0, (V_EXP[i] == 14'h0)});
        end

        // R3: second clock source alone sets bit 2
        @(negedge clk); clk_b_fail = 1; wr_en = 0;
        @(posedge clk); #1;
        chk("R3 clk_b", rd_data, 14'h0004);
        @(negedge clk); clk_b_fail = 0;

        // R7/R2: write of reserved bits only changes nothing, bits 1:0 stay 0
        step(12'h000, 1'b1, 14'h0003);
        chk("R7 rsvd write", rd_data, 14'h0004);
        chk("R2 rsvd read", {12'b0, rd_data[1:0]}, 14'h0000);

        // R6: open-wire flag 0 blocks its clear while others clear
        @(negedge clk); ow_flags = 13'h0001; wr_en = 0;
        @(posedge clk); #1;
        chk("R4 ow flag0", rd_data, 14'h0084);
        step(12'h000, 1'b0, 14'h0);
        @(negedge clk); ow_flags = 13'h0001; wr_en = 1; wr_data = 14'h0;
        @(posedge clk); #1;
        chk("R6 ow held", rd_data, 14'h0080);
        step(12'h000, 1'b1, 14'h0);
        chk("R6 ow freed", rd_data, 14'h0000);

        // R1: reset mid-run clears a full word
        step(12'hFFF, 1'b0, 14'h0);
        chk("R3 full", rd_data, 14'h3FFC);
        @(negedge clk); drive_ev(12'h000); rst_n = 0;
        @(posedge clk); #1;
        chk("R1 mid reset", rd_data, 14'h0000);
        chk("R1 mid line", {13'b0, fault_n}, 14'h0001);
        @(negedge clk); rst_n = 1;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule